// File: doc/BRIEF.md
# Paged PHY Management Access Controller

This block lets a host reach registers inside external PHYs over a two-wire management interface. The PHYs use a paged register space. The host loads three registers and then sets a start bit. The first register holds a one-hot port mask. The second holds the command word: start, direction, target register, page and a stored park page. The third holds the port number and write data in its upper half, and read results come back in its lower half.

A launched command first checks its arguments. It then runs three management frames to the same PHY address:
1. A write of the page number to PHY register 31.
2. The real read or write of the target register.
3. A write of the stored park page back to register 31.

When the three frames finish, the start bit clears, and a read result is placed in the data register. A read aimed at a port number above 31 returns 0xFFFF and sends no frame. A write whose mask does not select exactly one port is dropped.

The sequencer has these states: `ST_IDLE`, `ST_CHECK`, `ST_PAGE_GO`, `ST_PAGE_WAIT`, `ST_XFER_GO`, `ST_XFER_WAIT`, `ST_PARK_GO`, `ST_PARK_WAIT` and `ST_FINISH`. Its transitions are:
- IDLE goes to CHECK when the start bit is seen.
- CHECK goes to PAGE_GO if the arguments are valid, and to FINISH if they are not.
- Each GO state goes to its WAIT state after one cycle.
- Each WAIT state goes to the next GO state when its frame ends. PARK_WAIT goes to FINISH instead.
- FINISH goes back to IDLE.

Top module: `phy_mgmt_ctrl`

## Requirements
- R1: After reset, every register reads 0, including address 3, which always reads 0. MDC is low and the data line is released (`mdio_oe` low).
- R2: Writing address 1 with bit 0 set while idle makes bit 0 of address 1 read 1 on the next cycle. Bit 0 stays 1 until the whole command has completed, and then reads 0.
- R3: A valid command sends exactly three frames, in this order, all to the same PHY address:
  1. A write to register 31 with data equal to the page (address 1, bits 14:3).
  2. The target access to the register in address 1, bits 24:20.
  3. A write to register 31 with data equal to the park page (address 1, bits 19:15).
- R4: A read is selected when address 1, bit 2 is 0. It uses the port in address 2, bits 20:16, as the PHY address. The 16-bit result goes into address 2, bits 15:0, and bits 31:16 are left unchanged.
- R5: A write is selected when address 1, bit 2 is 1. It sends address 2, bits 31:16, as data. The PHY address is the index of the single set bit in address 0.
- R6: A read whose port value (address 2, bits 31:16) is above 31 sends no frame, sets address 2, bits 15:0, to 0xFFFF and then clears the start bit.
- R7: A write whose mask in address 0 has zero bits set, or more than one bit set, sends no frame. It leaves address 2 unchanged and then clears the start bit.
- R8: A write to address 1 with bit 0 set keeps the old values of bits 19:15 and bit 1. A write with bit 0 clear loads all of bits 24:0.
- R9: While the start bit is set, host writes to addresses 0, 1 and 2 are ignored.
- R10: Each frame has the following fields, each sent MSB first:
  - 32 preamble ones
  - start code 01
  - opcode: 01 for a write, 10 for a read
  - 5-bit PHY address, then 5-bit register address
  - turnaround: 10 on a write; on a read the controller releases the line
  - 16 data bits

  During read turnaround and read data, `mdio_oe` is low. One MDC period is CLK_DIV clocks.
- R11: While no command is in progress, MDC stays low and `mdio_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Register address: 0 mask, 1 command, 2 data |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Register read data for host_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The assertions check the following on every cycle:
- The management bus is quiet whenever the start bit is clear.
- The mask and the park fields stay frozen while a command is busy.
- A command-launch write keeps the park fields.
- A launch raises the busy bit on the next cycle.

The bench's scenarios cover what the assertions cannot see:
- Frame content and frame order, decoded by a responder that keeps its own page state.
- Read data returned through that page state.
- The port-mask decode.
- The two rejection paths.
- The MDC period.

The bench also checks on every clock that the controller never drives the line while the responder does.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int PORT_W    = 5;
    localparam int MASK_W    = 1 << PORT_W;
    localparam int PAGE_W    = 12;
    localparam int REGAD_W   = 5;
    localparam int PARK_W    = 5;
    localparam int DATA_W    = 16;
    localparam int WORD_W    = 32;

    localparam int GO_BIT    = 0;
    localparam int KEEP_BIT  = 1;
    localparam int WR_BIT    = 2;
    localparam int PAGE_LSB  = 3;
    localparam int PARK_LSB  = 15;
    localparam int REGAD_LSB = 20;
    localparam int CMD_W     = REGAD_LSB + REGAD_W;

    localparam logic [REGAD_W-1:0] PAGE_SEL_REG = 5'd31;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_PAGE_GO,
        ST_PAGE_WAIT,
        ST_XFER_GO,
        ST_XFER_WAIT,
        ST_PARK_GO,
        ST_PARK_WAIT,
        ST_FINISH
    } seq_state_t;

    typedef struct packed {
        logic                is_read;
        logic [PORT_W-1:0]   phy;
        logic [REGAD_W-1:0]  regad;
        logic [DATA_W-1:0]   wdata;
    } frame_req_t;

endpackage

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_we,
    input  logic [1:0]          host_addr,
    input  logic [WORD_W-1:0]   host_wdata,
    output logic [WORD_W-1:0]   host_rdata,
    input  logic                done_i,
    input  logic                rd_load_i,
    input  logic [DATA_W-1:0]   rd_val_i,
    output logic [MASK_W-1:0]   mask_o,
    output logic [CMD_W-1:0]    cmd_o,
    output logic [WORD_W-1:0]   data_o
);

    logic [MASK_W-1:0] mask_q;
    logic [CMD_W-1:0]  cmd_q;
    logic [WORD_W-1:0] data_q;
    logic              busy;

    assign busy = cmd_q[GO_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            cmd_q  <= '0;
            data_q <= '0;
        end else begin
            if (done_i) begin
                cmd_q[GO_BIT] <= 1'b0;
            end
            if (rd_load_i) begin
                data_q[DATA_W-1:0] <= rd_val_i;
            end
            if (host_we && !busy) begin
                unique case (host_addr)
                    2'd0: mask_q <= host_wdata[MASK_W-1:0];
                    2'd1: begin
                        if (host_wdata[GO_BIT]) begin
                            cmd_q[CMD_W-1:REGAD_LSB]   <= host_wdata[CMD_W-1:REGAD_LSB];
                            cmd_q[PARK_LSB-1:WR_BIT]   <= host_wdata[PARK_LSB-1:WR_BIT];
                            cmd_q[GO_BIT]              <= 1'b1;
                        end else begin
                            cmd_q <= host_wdata[CMD_W-1:0];
                        end
                    end
                    2'd2: data_q[WORD_W-1:DATA_W] <= host_wdata[WORD_W-1:DATA_W];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (host_addr)
            2'd0:    host_rdata = mask_q;
            2'd1:    host_rdata = {{(WORD_W-CMD_W){1'b0}}, cmd_q};
            2'd2:    host_rdata = data_q;
            default: host_rdata = '0;
        endcase
    end

    assign mask_o = mask_q;
    assign cmd_o  = cmd_q;
    assign data_o = data_q;

endmodule

// File: rtl/phy_mgmt_shifter.sv
module phy_mgmt_shifter
    import phy_mgmt_pkg::*;
#(
    parameter int CLK_DIV = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  frame_req_t        req_i,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);

    localparam int PH_W        = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam int HALF        = CLK_DIV / 2;
    localparam int FRAME_BITS  = 64;
    localparam int BIT_W       = $clog2(FRAME_BITS);
    localparam int TA_FIRST    = 46;
    localparam int DATA_FIRST  = 48;
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(CLK_DIV - 1);
    localparam logic [PH_W-1:0]  PH_HALF  = PH_W'(HALF);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

    logic                  active_q;
    logic                  rd_q;
    logic [PH_W-1:0]       phase_q;
    logic [BIT_W-1:0]      bitn_q;
    logic [FRAME_BITS-1:0] sh_q;
    logic [DATA_W-1:0]     cap_q;
    logic                  done_q;
    logic                  bit_end;

    assign bit_end = active_q && (phase_q == PH_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            rd_q     <= 1'b0;
            phase_q  <= '0;
            bitn_q   <= '0;
            sh_q     <= '0;
            cap_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= bit_end && (bitn_q == BIT_LAST);
            if (start_i && !active_q) begin
                active_q <= 1'b1;
                rd_q     <= req_i.is_read;
                phase_q  <= '0;
                bitn_q   <= '0;
                sh_q     <= {32'hFFFF_FFFF, 2'b01,
                             req_i.is_read ? 2'b10 : 2'b01,
                             req_i.phy, req_i.regad,
                             req_i.is_read ? 2'b11 : 2'b10,
                             req_i.is_read ? 16'hFFFF : req_i.wdata};
            end else if (active_q) begin
                if (bit_end) begin
                    phase_q <= '0;
                    sh_q    <= {sh_q[FRAME_BITS-2:0], 1'b1};
                    if (rd_q && (bitn_q >= BIT_W'(DATA_FIRST))) begin
                        cap_q <= {cap_q[DATA_W-2:0], mdio_i};
                    end
                    if (bitn_q == BIT_LAST) begin
                        active_q <= 1'b0;
                    end else begin
                        bitn_q <= bitn_q + 1'b1;
                    end
                end else begin
                    phase_q <= phase_q + 1'b1;
                end
            end
        end
    end

    assign mdc     = active_q && (phase_q >= PH_HALF);
    assign mdio_o  = active_q ? sh_q[FRAME_BITS-1] : 1'b1;
    assign mdio_oe = active_q && !(rd_q && (bitn_q >= BIT_W'(TA_FIRST)));
    assign done_o  = done_q;
    assign rdata_o = cap_q;

endmodule

// File: rtl/phy_mgmt_seq.sv
module phy_mgmt_seq
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic              sh_done_i,
    input  logic [DATA_W-1:0] sh_rdata_i,
    output logic              sh_start_o,
    output frame_req_t        sh_req_o,
    output logic              done_o,
    output logic              rd_load_o,
    output logic [DATA_W-1:0] rd_val_o
);

    seq_state_t state_q, state_d;

    logic              busy;
    logic              is_read;
    logic              args_ok;
    logic [PORT_W-1:0] mask_idx;
    logic [PORT_W-1:0] phy_q;
    logic              load_q;
    logic [DATA_W-1:0] result_q;

    assign busy    = cmd_i[GO_BIT];
    assign is_read = !cmd_i[WR_BIT];

    always_comb begin
        mask_idx = '0;
        for (int i = 0; i < MASK_W; i++) begin
            if (mask_i[i]) mask_idx = mask_idx | PORT_W'(i);
        end
    end

    always_comb begin
        if (is_read) args_ok = (data_i[WORD_W-1:DATA_W+PORT_W] == '0);
        else         args_ok = ($countones(mask_i) == 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (busy)      state_d = ST_CHECK;
            ST_CHECK:     state_d = args_ok ? ST_PAGE_GO : ST_FINISH;
            ST_PAGE_GO:   state_d = ST_PAGE_WAIT;
            ST_PAGE_WAIT: if (sh_done_i) state_d = ST_XFER_GO;
            ST_XFER_GO:   state_d = ST_XFER_WAIT;
            ST_XFER_WAIT: if (sh_done_i) state_d = ST_PARK_GO;
            ST_PARK_GO:   state_d = ST_PARK_WAIT;
            ST_PARK_WAIT: if (sh_done_i) state_d = ST_FINISH;
            ST_FINISH:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phy_q    <= '0;
            load_q   <= 1'b0;
            result_q <= '0;
        end else begin
            if (state_q == ST_CHECK) begin
                phy_q    <= is_read ? data_i[DATA_W +: PORT_W] : mask_idx;
                load_q   <= is_read;
                result_q <= 16'hFFFF;
            end
            if ((state_q == ST_XFER_WAIT) && sh_done_i && is_read) begin
                result_q <= sh_rdata_i;
            end
        end
    end

    always_comb begin
        sh_start_o       = 1'b0;
        sh_req_o.is_read = 1'b0;
        sh_req_o.phy     = phy_q;
        sh_req_o.regad   = PAGE_SEL_REG;
        sh_req_o.wdata   = {{(DATA_W-PAGE_W){1'b0}}, cmd_i[PAGE_LSB +: PAGE_W]};
        done_o           = 1'b0;
        rd_load_o        = 1'b0;
        unique case (state_q)
            ST_PAGE_GO: sh_start_o = 1'b1;
            ST_XFER_GO, ST_XFER_WAIT: begin
                sh_start_o       = (state_q == ST_XFER_GO);
                sh_req_o.is_read = is_read;
                sh_req_o.regad   = cmd_i[REGAD_LSB +: REGAD_W];
                sh_req_o.wdata   = data_i[WORD_W-1:DATA_W];
            end
            ST_PARK_GO, ST_PARK_WAIT: begin
                sh_start_o     = (state_q == ST_PARK_GO);
                sh_req_o.wdata = {{(DATA_W-PARK_W){1'b0}}, cmd_i[PARK_LSB +: PARK_W]};
            end
            ST_FINISH: begin
                done_o    = 1'b1;
                rd_load_o = load_q;
            end
            default: ;
        endcase
    end

    assign rd_val_o = result_q;

endmodule

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
    import phy_mgmt_pkg::*;
#(
    parameter int CLK_DIV = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [1:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    logic [MASK_W-1:0] mask_w;
    logic [CMD_W-1:0]  cmd_w;
    logic [WORD_W-1:0] data_w;
    logic              seq_done;
    logic              rd_load;
    logic [DATA_W-1:0] rd_val;
    logic              sh_start;
    logic              sh_done;
    logic [DATA_W-1:0] sh_rdata;
    frame_req_t        sh_req;

    phy_mgmt_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .done_i     (seq_done),
        .rd_load_i  (rd_load),
        .rd_val_i   (rd_val),
        .mask_o     (mask_w),
        .cmd_o      (cmd_w),
        .data_o     (data_w)
    );

    phy_mgmt_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (cmd_w),
        .mask_i     (mask_w),
        .data_i     (data_w),
        .sh_done_i  (sh_done),
        .sh_rdata_i (sh_rdata),
        .sh_start_o (sh_start),
        .sh_req_o   (sh_req),
        .done_o     (seq_done),
        .rd_load_o  (rd_load),
        .rd_val_o   (rd_val)
    );

    phy_mgmt_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (sh_start),
        .req_i   (sh_req),
        .done_o  (sh_done),
        .rdata_o (sh_rdata),
        .mdc     (mdc),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .mdio_i  (mdio_i)
    );

endmodule

// File: rtl/phy_mgmt_ctrl_chk.sv
module phy_mgmt_ctrl_chk #(
    parameter int MASK_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mdc,
    input logic              mdio_oe,
    input logic              host_we,
    input logic [1:0]        host_addr,
    input logic [31:0]       host_wdata,
    input logic [MASK_W-1:0] mask_q,
    input logic [5:0]        park_q
);

    logic launch;
    assign launch = !busy && host_we && (host_addr == 2'd1) && host_wdata[0];

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    assert_mask_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_we) |=> $stable(mask_q));

    assert_park_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_we) |=> $stable(park_q));

    assert_park_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> $stable(park_q));

    assert_launch_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy);

endmodule

bind phy_mgmt_ctrl phy_mgmt_ctrl_chk #(.MASK_W(MASK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (cmd_w[0]),
    .mdc        (mdc),
    .mdio_oe    (mdio_oe),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .mask_q     (mask_w),
    .park_q     ({cmd_w[19:15], cmd_w[1]})
);

// File: tb/phy_mgmt_ctrl_bench.sv
`timescale 1ns/1ps
module phy_mgmt_ctrl_bench;

    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    phy_mgmt_ctrl #(.CLK_DIV(DIV)) u_phy_mgmt_ctrl (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // ---------------- PHY responder (behavioural model) ----------------
    logic        phy_drv = 1'b0;
    logic        phy_bit = 1'b1;
    logic        mdio_line;
    int          ones = 0;
    bit          st_wait = 0;
    bit          in_frame = 0;
    int          k = 0;
    logic [29:0] fld = '0;
    bit          rdop = 0;
    logic [4:0]  f_phy = '0;
    logic [4:0]  f_reg = '0;
    logic [15:0] rval = '0;
    logic [11:0] page_cur = '0;
    logic [26:0] got_q[$];
    int          contention = 0;
    time         t_rise = 0;
    time         t_per = 0;

    assign mdio_line = mdio_oe ? mdio_o : (phy_drv ? phy_bit : 1'b1);
    assign mdio_i    = mdio_line;

    always @(posedge mdc) begin
        if (t_rise != 0) t_per = $time - t_rise;
        t_rise = $time;
        if (!in_frame) begin
            if (st_wait) begin
                st_wait = 0; in_frame = 1; k = 0;
            end else if (mdio_line) ones++;
            else begin
                if (ones >= 32) st_wait = 1;
                ones = 0;
            end
        end else begin
            fld = {fld[28:0], mdio_line};
            k++;
            if (k == 12) begin
                rdop  = (fld[11:10] == 2'b10);
                f_phy = fld[9:5];
                f_reg = fld[4:0];
                rval  = {f_phy, f_reg, page_cur[5:0]};
            end
            if (k == 30) begin
                got_q.push_back({rdop, f_phy, f_reg, rdop ? rval : fld[15:0]});
                if (!rdop && f_reg == 5'd31) page_cur = fld[11:0];
                in_frame = 0; ones = 0;
            end
        end
    end

    always @(negedge mdc) begin
        if (in_frame && rdop && k >= 13 && k <= 29) begin
            phy_drv = 1'b1;
            phy_bit = (k == 13) ? 1'b0 : rval[29-k];
        end else phy_drv = 1'b0;
    end

    // per-clock comparison: controller never drives while the responder does (R10)
    always @(posedge clk) if (phy_drv && mdio_oe) contention++;

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    function automatic logic [31:0] cw(input bit w, input logic [4:0] r, input logic [11:0] pg,
                                       input logic [4:0] pk, input bit keep, input bit go);
        return {7'b0, r, pk, pg, w, keep, go};
    endfunction

    function automatic logic [26:0] ev(input bit r, input logic [4:0] p, input logic [4:0] g, input logic [15:0] d);
        return {r, p, g, d};
    endfunction

    task automatic wait_idle(input string tag);
        logic [31:0] v;
        int n = 0;
        do begin rd(2'd1, v); n++; end while (v[0] && n < 4000);
        check(!v[0], tag, v, 32'h0);
    endtask

    task automatic cmp_frames(input string tag, input logic [26:0] e0, input logic [26:0] e1, input logic [26:0] e2);
        check(got_q.size() == 3, {tag, " frame count"}, got_q.size(), 3);
        if (got_q.size() == 3) begin
            check(got_q[0] == e0, {tag, " page frame"},   {5'b0, got_q[0]}, {5'b0, e0});
            check(got_q[1] == e1, {tag, " access frame"}, {5'b0, got_q[1]}, {5'b0, e1});
            check(got_q[2] == e2, {tag, " park frame"},   {5'b0, got_q[2]}, {5'b0, e2});
        end
        got_q.delete();
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check(v == 0, "R1 reset register", v, 0);
        end
        check(!mdc && !mdio_oe, "R1 bus idle", {mdc, mdio_oe}, 0);

        // R8: configuration write loads park and keep bits
        wr(2'd1, cw(0, 5'd0, 12'h000, 5'h13, 1, 0));
        rd(2'd1, v);
        check(v == cw(0, 5'd0, 12'h000, 5'h13, 1, 0), "R8 config load", v, cw(0, 5'd0, 12'h000, 5'h13, 1, 0));

        // R4/R3: read port 7, register 9, page 0x2A5
        wr(2'd2, 32'h0007_0000);
        wr(2'd1, cw(0, 5'd9, 12'h2A5, 5'h00, 0, 1));
        rd(2'd1, v);
        check(v[0], "R2 busy after launch", v, 1);
        // R9: writes while busy ignored
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd2, 32'h1234_0000);
        wr(2'd1, cw(1, 5'd1, 12'h001, 5'h01, 0, 0));
        wait_idle("R2 busy clears after read");
        cmp_frames("R3 read", ev(0, 7, 31, 16'h02A5), ev(1, 7, 9, {5'd7, 5'd9, 6'h25}), ev(0, 7, 31, 16'h0013));
        rd(2'd2, v);
        check(v == {16'h0007, 5'd7, 5'd9, 6'h25}, "R4 read result", v, {16'h0007, 5'd7, 5'd9, 6'h25});
        rd(2'd1, v);
        check(v == cw(0, 5'd9, 12'h2A5, 5'h13, 1, 0), "R8 park kept", v, cw(0, 5'd9, 12'h2A5, 5'h13, 1, 0));
        rd(2'd0, v);
        check(v == 0, "R9 mask unchanged", v, 0);
        check(t_per == time'(DIV * 5), "R10 MDC period", 32'(t_per), DIV * 5);

        // R5: write port 22, register 4, max page
        wr(2'd0, 32'h0040_0000);
        wr(2'd2, 32'hBEEF_0000);
        wr(2'd1, cw(1, 5'd4, 12'hFFF, 5'h00, 0, 1));
        wait_idle("R2 busy clears after write");
        cmp_frames("R5 write p22", ev(0, 22, 31, 16'h0FFF), ev(0, 22, 4, 16'hBEEF), ev(0, 22, 31, 16'h0013));
        rd(2'd2, v);
        check(v == {16'hBEEF, 5'd7, 5'd9, 6'h25}, "R5 data low kept", v, {16'hBEEF, 5'd7, 5'd9, 6'h25});

        // R5 boundary: port 31, register 31
        wr(2'd0, 32'h8000_0000);
        wr(2'd1, cw(1, 5'd31, 12'h040, 5'h00, 0, 1));
        wait_idle("R2 busy clears p31");
        cmp_frames("R5 write p31", ev(0, 31, 31, 16'h0040), ev(0, 31, 31, 16'hBEEF), ev(0, 31, 31, 16'h0013));

        // R4 boundary: read port 31 register 0 after page 0x03F
        wr(2'd2, 32'h001F_0000);
        wr(2'd1, cw(0, 5'd0, 12'h03F, 5'h00, 0, 1));
        wait_idle("R2 busy clears p31 read");
        cmp_frames("R4 read p31", ev(0, 31, 31, 16'h003F), ev(1, 31, 0, {5'd31, 5'd0, 6'h3F}), ev(0, 31, 31, 16'h0013));
        rd(2'd2, v);
        check(v == {16'h001F, 5'd31, 5'd0, 6'h3F}, "R4 read p31 result", v, {16'h001F, 5'd31, 5'd0, 6'h3F});

        // R6: read of port 32 rejected
        wr(2'd2, 32'h0020_0000);
        wr(2'd1, cw(0, 5'd2, 12'h001, 5'h00, 0, 1));
        wait_idle("R6 busy clears");
        check(got_q.size() == 0, "R6 no frames", got_q.size(), 0);
        rd(2'd2, v);
        check(v == 32'h0020_FFFF, "R6 result FFFF", v, 32'h0020_FFFF);
        got_q.delete();

        // R7: write with two mask bits, then zero mask
        wr(2'd2, 32'h5555_0000);
        wr(2'd0, 32'h0000_0003);
        wr(2'd1, cw(1, 5'd2, 12'h001, 5'h00, 0, 1));
        wait_idle("R7 busy clears two bits");
        wr(2'd0, 32'h0000_0000);
        wr(2'd1, cw(1, 5'd2, 12'h001, 5'h00, 0, 1));
        wait_idle("R7 busy clears zero mask");
        check(got_q.size() == 0, "R7 no frames", got_q.size(), 0);
        rd(2'd2, v);
        check(v == 32'h5555_FFFF, "R7 data unchanged", v, 32'h5555_FFFF);
        got_q.delete();

        // R11: idle bus stays quiet
        begin
            int moved = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (mdc || mdio_oe) moved++;
            end
            check(moved == 0, "R11 idle bus", moved, 0);
        end
        check(contention == 0, "R10 line released during read", contention, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule